// File: doc/BRIEF.md
# Deterministic D/T Ring Test Vector Source

This block is a self-test stimulus source. It plays a fixed list of deterministic test vectors into a unit under test, one vector per advance, with no filler vectors between them. The state is held in a ring of `WIDTH` cells. Each cell is fixed at elaboration as either a data-type (D) stage or a toggle-type (T) stage, and each cell may also have an inverter on its input.

A combinational fix-up decoder looks at the current ring state. From it, the decoder drives one correction bit per cell, so that the next clock with advance high lands exactly on the next listed vector. The vector list, the cell types and the inverter mask are all parameters. The decoder is built from them during elaboration, so it always matches the chosen ring structure.

The `advance` input lets the surrounding logic step the source only in cycles when the unit under test is idle. A `done` flag marks the last vector. One more advance after that reloads the first vector, so the list plays again.

Top module: `dtr_pattern_gen`

## Requirements
- R1: After reset, `pattern` equals vector 0 of the list. `done` is low, unless the list holds a single vector. Vector k occupies bits `[k*WIDTH +: WIDTH]` of `VECTORS`, and bit j of `pattern` is ring cell j.
- R2: When `advance` is high while `done` is low, the following cycle shows the next vector in list order, with no other value in between.
- R3: When `advance` is low, `pattern` and `done` keep their values.
- R4: `done` is high exactly while the last listed vector is on `pattern`.
- R5: When `advance` is high while `done` is high, the following cycle shows vector 0 again, and `done` is low if the list holds more than one vector.
- R6: Cell j loads `(t_j & q_j) ^ q_(j-1) ^ inv_j ^ f_j`, and cell 0 takes cell `WIDTH-1` as its neighbour. The listed sequence is produced unchanged for any mix of cell types and inverters: all-D without inverters, all-T with inverters, or mixed.
- R7: A list of one vector holds that vector on `pattern` through any number of advances, with `done` permanently high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the ring updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; loads vector 0 |
| advance | input | 1 | Step to the next listed vector when high |
| pattern | output | WIDTH | Current test vector (the ring state) |
| done | output | 1 | High while the last listed vector is shown |

## Verification
The bench builds four copies of the block. Three share one six-entry, 8-bit list but differ in ring structure: a mixed T/D ring with some inverters, an all-D ring without inverters, and an all-T ring with every inverter present. Between them, these reach the pure shift form, the pure toggle form and the mixed decoder. The fourth copy is a 4-bit, single-entry list, which reaches the degenerate case where the last vector is also the first. Advances are interleaved with idle gaps to exercise holding, the last-vector flag and the wrap back to the start.

// File: rtl/dtr_pkg.sv
package dtr_pkg;

  // Next value loaded by one ring cell.
  function automatic logic cell_next(input logic is_t, input logic has_inv,
                                     input logic q_self, input logic q_prev,
                                     input logic fix);
    return (is_t & q_self) ^ q_prev ^ has_inv ^ fix;
  endfunction

  // Correction a cell needs so that it loads q_want.
  function automatic logic cell_corr(input logic is_t, input logic has_inv,
                                     input logic q_self, input logic q_prev,
                                     input logic q_want);
    return (is_t & q_self) ^ q_prev ^ has_inv ^ q_want;
  endfunction

  // Index width for a list of n entries (at least one bit).
  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/dtr_ring_cell.sv
module dtr_ring_cell
  import dtr_pkg::*;
#(
  parameter bit IS_T    = 1'b0,
  parameter bit HAS_INV = 1'b0,
  parameter bit SEED    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic q_prev,
  input  logic fix,
  output logic q
);

  logic d_in;
  assign d_in = cell_next(IS_T, HAS_INV, q, q_prev, fix);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= SEED;
    else if (step) q <= d_in;
  end

endmodule

// File: rtl/dtr_fix_decoder.sv
module dtr_fix_decoder
  import dtr_pkg::*;
#(
  parameter int                         WIDTH    = 8,
  parameter int                         NUM_VEC  = 6,
  parameter logic [NUM_VEC*WIDTH-1:0]   VECTORS  = '0,
  parameter logic [WIDTH-1:0]           CELL_T   = '0,
  parameter logic [WIDTH-1:0]           CELL_INV = '0
) (
  input  logic [WIDTH-1:0] state,
  output logic [WIDTH-1:0] fix,
  output logic             in_seq
);

  logic [WIDTH-1:0] cur_v;
  logic [WIDTH-1:0] nxt_v;

  // Each listed state maps to the correction that lands on its successor;
  // the last entry maps back to entry 0. Other states are don't-care (zero).
  always_comb begin
    fix    = '0;
    in_seq = 1'b0;
    cur_v  = '0;
    nxt_v  = '0;
    for (int k = 0; k < NUM_VEC; k++) begin
      if (!in_seq && state == VECTORS[k*WIDTH +: WIDTH]) begin
        in_seq = 1'b1;
        cur_v  = VECTORS[k*WIDTH +: WIDTH];
        nxt_v  = VECTORS[((k + 1) % NUM_VEC)*WIDTH +: WIDTH];
        for (int j = 0; j < WIDTH; j++) begin
          fix[j] = cell_corr(CELL_T[j], CELL_INV[j], cur_v[j],
                             cur_v[(j + WIDTH - 1) % WIDTH], nxt_v[j]);
        end
      end
    end
  end

endmodule

// File: rtl/dtr_seq_ctr.sv
module dtr_seq_ctr #(
  parameter int NUM_VEC = 6,
  parameter int IDX_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx,
  output logic             at_last
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_VEC - 1);

  assign at_last = (idx == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     idx <= '0;
    else if (step)  idx <= at_last ? '0 : idx + 1'b1;
  end

endmodule

// File: rtl/dtr_pattern_gen.sv
module dtr_pattern_gen
  import dtr_pkg::*;
#(
  parameter int                         WIDTH    = 8,
  parameter int                         NUM_VEC  = 6,
  parameter logic [NUM_VEC*WIDTH-1:0]   VECTORS  = 48'h5E_81_FF_00_A5_3C,
  parameter logic [WIDTH-1:0]           CELL_T   = 8'b1010_0110,
  parameter logic [WIDTH-1:0]           CELL_INV = 8'b0011_0101
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [WIDTH-1:0] pattern,
  output logic             done
);

  localparam int               IDX_W = idx_bits(NUM_VEC);
  localparam logic [WIDTH-1:0] SEED  = VECTORS[WIDTH-1:0];

  logic [WIDTH-1:0] ring_q;
  logic [WIDTH-1:0] ring_fix;
  logic             in_seq;
  logic [IDX_W-1:0] seq_idx;

  dtr_fix_decoder #(
    .WIDTH(WIDTH), .NUM_VEC(NUM_VEC), .VECTORS(VECTORS),
    .CELL_T(CELL_T), .CELL_INV(CELL_INV)
  ) u_dec (
    .state  (ring_q),
    .fix    (ring_fix),
    .in_seq (in_seq)
  );

  for (genvar j = 0; j < WIDTH; j++) begin : g_cell
    dtr_ring_cell #(
      .IS_T(CELL_T[j]), .HAS_INV(CELL_INV[j]), .SEED(SEED[j])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (advance),
      .q_prev (ring_q[(j + WIDTH - 1) % WIDTH]),
      .fix    (ring_fix[j]),
      .q      (ring_q[j])
    );
  end

  dtr_seq_ctr #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .step    (advance),
    .idx     (seq_idx),
    .at_last (done)
  );

  assign pattern = ring_q;

endmodule

// File: rtl/dtr_pattern_gen_chk.sv
module dtr_pattern_gen_chk #(
  parameter int                       WIDTH   = 8,
  parameter int                       NUM_VEC = 6,
  parameter logic [NUM_VEC*WIDTH-1:0] VECTORS = '0,
  parameter int                       IDX_W   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             advance,
  input logic [WIDTH-1:0] pattern,
  input logic             done,
  input logic [IDX_W-1:0] seq_idx,
  input logic             in_seq
);

  function automatic logic [WIDTH-1:0] vec_at(input logic [IDX_W-1:0] i);
    return VECTORS[int'(i)*WIDTH +: WIDTH];
  endfunction

  localparam logic [WIDTH-1:0] FIRST_V = VECTORS[WIDTH-1:0];
  localparam logic [WIDTH-1:0] LAST_V  = VECTORS[(NUM_VEC-1)*WIDTH +: WIDTH];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !advance |=> ($stable(pattern) && $stable(done))); // R3
  AST_TRACK_LIST: assert property (@(posedge clk) disable iff (!rst_n)
    pattern == vec_at(seq_idx)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && !done) |=> (seq_idx == IDX_W'($past(seq_idx) + 1'b1))); // R2
  AST_WRAP_SEED: assert property (@(posedge clk) disable iff (!rst_n)
    (advance && done) |=> (pattern == FIRST_V)); // R5
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done == (pattern == LAST_V)); // R4
  AST_STATE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    in_seq); // R6

endmodule

bind dtr_pattern_gen dtr_pattern_gen_chk #(
  .WIDTH(WIDTH), .NUM_VEC(NUM_VEC), .VECTORS(VECTORS), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .advance(advance), .pattern(pattern),
  .done(done), .seq_idx(seq_idx), .in_seq(in_seq)
);

// File: tb/dtr_pattern_gen_tb.sv
`timescale 1ns/1ps
module dtr_pattern_gen_tb;

  localparam int           W  = 8;
  localparam int           NV = 6;
  localparam logic [NV*W-1:0] VL = 48'h5E_81_FF_00_A5_3C;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic advance = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] p_mix, p_d, p_t;
  logic         d_mix, d_d, d_t;
  logic [3:0]   p_one;
  logic         d_one;

  dtr_pattern_gen #(.WIDTH(W), .NUM_VEC(NV), .VECTORS(VL),
    .CELL_T(8'b1010_0110), .CELL_INV(8'b0011_0101)) u_dut (
    .clk(clk), .rst_n(rst_n), .advance(advance), .pattern(p_mix), .done(d_mix));
  dtr_pattern_gen #(.WIDTH(W), .NUM_VEC(NV), .VECTORS(VL),
    .CELL_T(8'h00), .CELL_INV(8'h00)) u_dut_alld (
    .clk(clk), .rst_n(rst_n), .advance(advance), .pattern(p_d), .done(d_d));
  dtr_pattern_gen #(.WIDTH(W), .NUM_VEC(NV), .VECTORS(VL),
    .CELL_T(8'hFF), .CELL_INV(8'hFF)) u_dut_allt (
    .clk(clk), .rst_n(rst_n), .advance(advance), .pattern(p_t), .done(d_t));
  dtr_pattern_gen #(.WIDTH(4), .NUM_VEC(1), .VECTORS(4'hA),
    .CELL_T(4'b0110), .CELL_INV(4'b1001)) u_dut_one (
    .clk(clk), .rst_n(rst_n), .advance(advance), .pattern(p_one), .done(d_one));

  int total = 0;
  int bad   = 0;
  int exp_idx = 0;

  function automatic logic [W-1:0] want(input int k);
    return VL[k*W +: W];
  endfunction

  task automatic chk(input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tick(input logic a);
    advance = a;
    @(negedge clk);
    if (a) exp_idx = (exp_idx == NV-1) ? 0 : exp_idx + 1;
  endtask

  // All three structures against the list position tracked here.
  task automatic chk_all(input string req);
    chk({req, " mixed"}, p_mix, want(exp_idx));
    chk({req, " all-D"}, p_d,   want(exp_idx));
    chk({req, " all-T"}, p_t,   want(exp_idx));
    chk({"R4 done mixed"}, {7'b0, d_mix}, {7'b0, exp_idx == NV-1});
    chk({"R4 done all-D"}, {7'b0, d_d},   {7'b0, exp_idx == NV-1});
    chk({"R4 done all-T"}, {7'b0, d_t},   {7'b0, exp_idx == NV-1});
  endtask

  task automatic t_reset;
    chk_all("R1 reset");
    chk("R7 single reset", {4'b0, p_one}, 8'h0A);
    chk("R7 single done",  {7'b0, d_one}, 8'h01);
  endtask

  task automatic t_walk;
    for (int k = 1; k < NV; k++) begin
      tick(1'b1);
      chk_all("R2 R6 walk");
      chk("R7 single hold", {4'b0, p_one}, 8'h0A);
    end
  endtask

  task automatic t_hold;
    for (int k = 0; k < 3; k++) begin
      tick(1'b0);
      chk_all("R3 idle");
    end
  endtask

  task automatic t_wrap;
    tick(1'b1);
    chk_all("R5 wrap");
    chk("R7 single wrap", {4'b0, p_one}, 8'h0A);
    chk("R7 single done", {7'b0, d_one}, 8'h01);
  endtask

  task automatic t_gappy;
    for (int k = 0; k < 2*NV; k++) begin
      tick(1'b1);
      chk_all("R2 R5 gapped");
      tick(1'b0);
      chk_all("R3 gap");
    end
  endtask

  task automatic finish_run;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200) @(negedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_walk();
    t_hold();
    t_wrap();
    t_hold();
    t_gappy();
    t_walk();
    finish_run();
  end

endmodule